// File: doc/BRIEF.md
# Predecode-Valid Tracker with Write Snooping

This block holds the bookkeeping that sits beside a cache of predecoded instructions. Memory is word-addressed and split into pages of 2^PAGE_W words. A bitmap, packed 32 page bits to a word, records which pages may hold cached decodes. For every word the block also keeps a valid bit, meaning "a decode is cached here", and a small set of breakpoint flags.

A command port marks regions as cacheable. Regions are rounded inward, so only whole pages are ever marked. The same port also:
- records a finished decode (fill),
- starts a range invalidate,
- sets or clears breakpoint flags.

A snoop port watches bus writes. Because an instruction can span three words, a write to word A discards the cached decodes at A, A-1 and A-2, wrapping within the address space. Invalidation never removes breakpoint flags. A lookup port reports cacheable, valid and flags for an address one cycle after the request.

A range invalidate walks one address per clock and holds `busy` until the walk is done. Snoop writes keep working during the walk. The decoded instruction storage itself lives elsewhere.

Top module: `pvt_tracker`

## Requirements
- R1: After reset every page is non-cacheable, every entry is invalid with no flags, `busy` and `bp_prev` are 0.
- R2: Command code 1 (mark) rounds `cmd_lo` up and `cmd_hi`+1 down to page boundaries and sets only the whole pages between them; an empty result marks nothing, and no command ever clears a page bit.
- R3: A snoop write to A clears the valid bits of A, A-1 and A-2 modulo 2^ADDR_W and of no other entry.
- R4: No invalidation (snoop or range) changes any breakpoint flag.
- R5: Command code 2 (range invalidate, `cmd_lo` <= `cmd_hi`) clears every valid bit from `cmd_lo` to `cmd_hi` inclusive, one per cycle. `busy` is high for exactly `cmd_hi`-`cmd_lo`+1 cycles, starting the cycle after acceptance. Commands presented while `busy` is high are ignored.
- R6: A snoop write arriving while `busy` is high still takes full effect.
- R7: Command code 3 (set breakpoint) ORs `cmd_flags` into the flags of `cmd_lo` and clears its valid bit. The next cycle, `bp_prev` shows whether any flag was set before.
- R8: Command code 4 (clear breakpoint) removes only the bits given in `cmd_flags`. The entry accepts a fill again only once no flag remains.
- R9: Command code 5 (fill) sets the valid bit of `cmd_lo` only if its page is cacheable and it has no flags; a snoop in the same cycle wins.
- R10: A lookup request yields `lk_rsp` in the next cycle, carrying the state as it stood at the request edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (1 mark, 2 invalidate, 3 set bp, 4 clear bp, 5 fill) |
| cmd_lo | input | ADDR_W | Low address, or the target address |
| cmd_hi | input | ADDR_W | High address for mark and invalidate |
| cmd_flags | input | FLAG_W | Breakpoint flag bits |
| busy | output | 1 | Range invalidate in progress |
| bp_prev | output | 1 | A breakpoint was already present at the last set |
| snp_valid | input | 1 | Snooped bus write strobe |
| snp_addr | input | ADDR_W | Snooped write address |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Lookup address |
| lk_rsp | output | 1 | Lookup result valid |
| lk_cacheable | output | 1 | Page of the looked-up address is cacheable |
| lk_valid | output | 1 | A decode is cached at the address |
| lk_flags | output | FLAG_W | Breakpoint flags at the address |

## Verification
The assertions check several things on every cycle: a snooped address is invalid one cycle later, flags change only on breakpoint commands, page bits are never removed, `busy` rises only after an accepted invalidate, and a valid result always reports a cacheable, flag-free entry. The bench scenarios are needed for the rest: the inward rounding at odd region ends, the exact reach of a snoop including wraparound at the top of the space, the length of the busy walk, a command ignored mid-walk, and the set/clear flag history with its `bp_prev` reply.

// File: rtl/pvt_pkg.sv
package pvt_pkg;
    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_MARK  = 3'd1,
        OP_INVAL = 3'd2,
        OP_SETBP = 3'd3,
        OP_CLRBP = 3'd4,
        OP_FILL  = 3'd5
    } pvt_op_e;
endpackage

// File: rtl/pvt_span.sv
// Turns an address range into a mask of the whole pages inside it.
module pvt_span #(
    parameter int ADDR_W = 10,
    parameter int PAGE_W = 3,
    localparam int PG_W   = ADDR_W - PAGE_W,
    localparam int NPAGES = 1 << PG_W
) (
    input  logic [ADDR_W-1:0] lo,
    input  logic [ADDR_W-1:0] hi,
    output logic [NPAGES-1:0] mask
);
    localparam logic [ADDR_W:0] ROUND = (ADDR_W+1)'((1 << PAGE_W) - 1);

    logic [ADDR_W:0] lo_up;
    logic [ADDR_W:0] hi_up;
    logic [PG_W:0]   first_pg;
    logic [PG_W:0]   limit_pg;

    assign lo_up    = {1'b0, lo} + ROUND;
    assign hi_up    = {1'b0, hi} + (ADDR_W+1)'(1);
    assign first_pg = lo_up[ADDR_W:PAGE_W];
    assign limit_pg = hi_up[ADDR_W:PAGE_W];

    for (genvar p = 0; p < NPAGES; p++) begin : g_page
        assign mask[p] = ((PG_W+1)'(p) >= first_pg) && ((PG_W+1)'(p) < limit_pg);
    end
endmodule

// File: rtl/pvt_tracker.sv
module pvt_tracker
    import pvt_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int PAGE_W = 3,
    parameter int FLAG_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_lo,
    input  logic [ADDR_W-1:0] cmd_hi,
    input  logic [FLAG_W-1:0] cmd_flags,
    output logic              busy,
    output logic              bp_prev,
    input  logic              snp_valid,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic              lk_req,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_rsp,
    output logic              lk_cacheable,
    output logic              lk_valid,
    output logic [FLAG_W-1:0] lk_flags
);
    localparam int ENTRIES = 1 << ADDR_W;
    localparam int PG_W    = ADDR_W - PAGE_W;
    localparam int NPAGES  = 1 << PG_W;
    localparam int NWORDS  = NPAGES / 32;

    typedef struct packed {
        logic [NWORDS-1:0][31:0]        bitmap;
        logic [ENTRIES-1:0]             valid;
        logic [ENTRIES-1:0][FLAG_W-1:0] flags;
        logic                           busy;
        logic [ADDR_W-1:0]              ptr;
        logic [ADDR_W-1:0]              endp;
        logic                           bp_prev;
        logic                           lk_rsp;
        logic                           lk_cache;
        logic                           lk_valid;
        logic [FLAG_W-1:0]              lk_flags;
    } state_t;

    state_t state_d, state_q;

    logic [NPAGES-1:0] span_mask;
    logic [NPAGES-1:0] page_flat;
    logic              accept;
    logic [FLAG_W-1:0] cur_flags;

    pvt_span #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_span (
        .lo   (cmd_lo),
        .hi   (cmd_hi),
        .mask (span_mask)
    );

    assign page_flat = state_q.bitmap;
    assign accept    = cmd_valid && !state_q.busy;
    assign cur_flags = state_q.flags[cmd_lo];

    always_comb begin
        state_d        = state_q;
        state_d.lk_rsp = lk_req;
        if (lk_req) begin
            state_d.lk_cache = page_flat[lk_addr[ADDR_W-1:PAGE_W]];
            state_d.lk_valid = state_q.valid[lk_addr];
            state_d.lk_flags = state_q.flags[lk_addr];
        end

        // one step of a running range invalidate
        if (state_q.busy) begin
            state_d.valid[state_q.ptr] = 1'b0;
            if (state_q.ptr == state_q.endp) begin
                state_d.busy = 1'b0;
            end else begin
                state_d.ptr = state_q.ptr + ADDR_W'(1);
            end
        end

        if (accept) begin
            case (cmd_op)
                OP_MARK: state_d.bitmap = state_q.bitmap | span_mask;
                OP_INVAL: begin
                    state_d.busy = 1'b1;
                    state_d.ptr  = cmd_lo;
                    state_d.endp = cmd_hi;
                end
                OP_SETBP: begin
                    state_d.bp_prev       = |cur_flags;
                    state_d.flags[cmd_lo] = cur_flags | cmd_flags;
                    state_d.valid[cmd_lo] = 1'b0;
                end
                OP_CLRBP: state_d.flags[cmd_lo] = cur_flags & ~cmd_flags;
                OP_FILL: begin
                    if (page_flat[cmd_lo[ADDR_W-1:PAGE_W]] && cur_flags == '0) begin
                        state_d.valid[cmd_lo] = 1'b1;
                    end
                end
                default: ;
            endcase
        end

        // snoop last so it overrides a fill to the same word
        if (snp_valid) begin
            state_d.valid[snp_addr]                = 1'b0;
            state_d.valid[snp_addr - ADDR_W'(1)]   = 1'b0;
            state_d.valid[snp_addr - ADDR_W'(2)]   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign busy         = state_q.busy;
    assign bp_prev      = state_q.bp_prev;
    assign lk_rsp       = state_q.lk_rsp;
    assign lk_cacheable = state_q.lk_cache;
    assign lk_valid     = state_q.lk_valid;
    assign lk_flags     = state_q.lk_flags;

    logic bp_cmd;
    assign bp_cmd = accept && (cmd_op == OP_SETBP || cmd_op == OP_CLRBP);

    // R2
    page_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((state_q.bitmap & $past(state_q.bitmap)) == $past(state_q.bitmap)));

    // R3
    snoop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |=> (!state_q.valid[$past(snp_addr)]
                    && !state_q.valid[$past(snp_addr) - ADDR_W'(2)]));

    // R4
    flags_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bp_cmd |=> $stable(state_q.flags));

    // R5
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q.busy) |-> $past(accept && cmd_op == OP_INVAL));

    // R9
    valid_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_rsp && lk_valid) |-> (lk_cacheable && lk_flags == '0));
endmodule

// File: tb/pvt_tracker_test.sv
module pvt_tracker_test;
    import pvt_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = '0;
    logic [AW-1:0] cmd_lo = '0, cmd_hi = '0;
    logic [1:0]    cmd_flags = '0;
    logic          busy, bp_prev;
    logic          snp_valid = 1'b0;
    logic [AW-1:0] snp_addr = '0;
    logic          lk_req = 1'b0;
    logic [AW-1:0] lk_addr = '0;
    logic          lk_rsp, lk_cacheable, lk_valid;
    logic [1:0]    lk_flags;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    typedef struct {
        logic [3:0] exp;
        int         addr;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pvt_tracker #(.ADDR_W(AW), .PAGE_W(3), .FLAG_W(2)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_lo(cmd_lo), .cmd_hi(cmd_hi), .cmd_flags(cmd_flags),
        .busy(busy), .bp_prev(bp_prev), .snp_valid(snp_valid), .snp_addr(snp_addr),
        .lk_req(lk_req), .lk_addr(lk_addr), .lk_rsp(lk_rsp),
        .lk_cacheable(lk_cacheable), .lk_valid(lk_valid), .lk_flags(lk_flags)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cmd(logic [2:0] op, int lo, int hi, int fl);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op;
        cmd_lo = AW'(lo); cmd_hi = AW'(hi); cmd_flags = 2'(fl);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic fill(int a);
        cmd(OP_FILL, a, a, 0);
    endtask

    task automatic snoop(int a);
        @(negedge clk);
        snp_valid = 1'b1; snp_addr = AW'(a);
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    // driver: expected = {cacheable, valid, flags}
    task automatic look(int a, int c, int v, int f, string tag);
        exp_t e;
        @(negedge clk);
        lk_req = 1'b1; lk_addr = AW'(a);
        e.exp = {1'(c), 1'(v), 2'(f)}; e.addr = a; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        lk_req = 1'b0;
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && lk_rsp) begin
            if (sb.size() == 0) begin
                check("R10 unexpected response", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check($sformatf("%s addr %0d {cache,valid,flags}", e.tag, e.addr),
                      int'({lk_cacheable, lk_valid, lk_flags}), int'(e.exp));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy after reset", int'(busy), 0);
        check("R1 bp_prev after reset", int'(bp_prev), 0);
        look(0, 0, 0, 0, "R1");
        look(1023, 0, 0, 0, "R1");

        // fill into a non-cacheable page
        fill(5);
        look(5, 0, 0, 0, "R9 fill ignored");

        // inward rounding: 3..30 covers pages 1 and 2 (words 8..23)
        cmd(OP_MARK, 3, 30, 0);
        look(7, 0, 0, 0, "R2 below");
        look(8, 1, 0, 0, "R2 first");
        look(23, 1, 0, 0, "R2 last");
        look(24, 0, 0, 0, "R2 above");
        cmd(OP_MARK, 41, 46, 0);
        look(41, 0, 0, 0, "R2 empty span");
        look(12, 1, 0, 0, "R2 kept");
        cmd(OP_MARK, 0, 7, 0);
        cmd(OP_MARK, 1016, 1023, 0);
        look(1023, 1, 0, 0, "R2 top page");

        // snoop reach
        for (int a = 10; a <= 15; a++) fill(a);
        fill(0); fill(1); fill(1021); fill(1022); fill(1023);
        look(10, 1, 1, 0, "R9 fill");
        snoop(12);
        look(10, 1, 0, 0, "R3 A-2");
        look(11, 1, 0, 0, "R3 A-1");
        look(12, 1, 0, 0, "R3 A");
        look(13, 1, 1, 0, "R3 A+1 untouched");
        snoop(1);
        look(1, 1, 0, 0, "R3 wrap A");
        look(0, 1, 0, 0, "R3 wrap A-1");
        look(1023, 1, 0, 0, "R3 wrap A-2");
        look(1022, 1, 1, 0, "R3 wrap untouched");

        // breakpoints
        cmd(OP_SETBP, 16, 16, 1);
        check("R7 bp_prev first set", int'(bp_prev), 0);
        cmd(OP_SETBP, 16, 16, 2);
        check("R7 bp_prev second set", int'(bp_prev), 1);
        fill(16);
        look(16, 1, 0, 3, "R9 fill blocked by flags");
        snoop(18);
        look(16, 1, 0, 3, "R4 snoop keeps flags");
        cmd(OP_CLRBP, 16, 16, 1);
        look(16, 1, 0, 2, "R8 partial clear");
        cmd(OP_CLRBP, 16, 16, 2);
        fill(16);
        look(16, 1, 1, 0, "R8 fill after last flag");
        cmd(OP_SETBP, 16, 16, 1);
        check("R7 bp_prev after clear", int'(bp_prev), 0);
        look(16, 1, 0, 1, "R7 set clears valid");

        // range invalidate with a snoop and an ignored command mid-walk
        for (int a = 17; a <= 23; a++) fill(a);
        fill(15);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = OP_INVAL; cmd_lo = AW'(16); cmd_hi = AW'(19);
        @(negedge clk);
        cmd_valid = 1'b0;
        cnt = 0;
        while (busy && cnt < 50) begin
            cnt++;
            snp_valid = (cnt == 1);
            snp_addr  = AW'(23);
            cmd_valid = (cnt == 2);
            cmd_op = OP_SETBP; cmd_lo = AW'(20); cmd_flags = 2'd1;
            @(negedge clk);
        end
        snp_valid = 1'b0; cmd_valid = 1'b0;
        check("R5 busy cycles", cnt, 4);
        look(15, 1, 1, 0, "R5 below range");
        look(16, 1, 0, 1, "R4 range keeps flags");
        look(17, 1, 0, 0, "R5 in range");
        look(19, 1, 0, 0, "R5 range end");
        look(20, 1, 1, 0, "R5 command ignored while busy");
        look(21, 1, 0, 0, "R6 snoop during busy");
        look(23, 1, 0, 0, "R6 snoop during busy");

        repeat (3) @(negedge clk);
        check("R10 responses outstanding", sb.size(), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule